// File: doc/BRIEF.md
# Two-Wire Register Port with Commit on Stop

This block is the serial slave front end of an 8-bit register file. It watches a sampled SCL/SDA pair, answers to one fixed 7-bit device address, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero bit. Writes and reads of one byte or of a block are supported. A register offset pointer sets the starting point, and it advances by one after each byte.

A write never reaches the live registers while the transaction is still running. Every complete data byte is held in a staging buffer. When the stop condition arrives, all staged bytes go out together in one strobe cycle, as a per-register mask and a full-width data vector. The register file therefore never shows a half-applied block.

A repeated start throws the staged bytes away. So does the loss of the serial-mode enable, which the configuration loader drives high only when the part started up in serial-bus mode. Reads fetch the live register contents through a separate address/data port.

Top module: `i2c_commit_regport`

## Requirements
- R1: With `bus_en` high, a start followed by the device address `DEV_ADDR` (address in bits 7:1, read/write flag in bit 0, 1 meaning read) is acknowledged by SDA held low through the ninth clock. Any other address is not acknowledged.
- R2: In a write, the first data byte sets the register offset from its low `$clog2(NREG)` bits. Each following byte goes to the next offset, wrapping from `NREG-1` to 0.
- R3: While a write transaction is still open, `reg_wr_stb` stays low.
- R4: On stop, `reg_wr_stb` pulses for one cycle. `reg_wr_mask` bit k is set for each staged offset k, and `reg_wr_data[8k+7:8k]` carries that byte. A stop with nothing staged gives no strobe.
- R5: A read returns the live byte at the current offset, most significant bit first, and advances the offset after each byte. `rd_addr` shows the offset. A master NACK ends the read and releases SDA.
- R6: A repeated start before stop discards all staged bytes, so nothing is written.
- R7: A partial byte (fewer than 8 bits) before stop is dropped. The complete bytes before it are still committed.
- R8: The staging buffer accepts `DEPTH` data bytes per transaction. Further bytes are not acknowledged and are not committed.
- R9: With `bus_en` low, the block acknowledges nothing and never strobes. Dropping `bus_en` in the middle of a write discards the staged bytes.
- R10: SDA is released (`sda_oe` low) after reset and after every stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Serial mode enable from the configuration loader |
| scl_i | input | 1 | Sampled serial clock |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | Pull SDA low when high |
| rd_addr | output | $clog2(NREG) | Live register read offset |
| rd_data | input | 8 | Live register read data for `rd_addr` |
| reg_wr_stb | output | 1 | One-cycle commit strobe |
| reg_wr_mask | output | NREG | Registers written by the commit |
| reg_wr_data | output | NREG*8 | Byte k at bits 8k+7:8k |

## Verification
Block writes are driven at a mid-file offset and across the top-of-file wrap. This shows whether the offset counter advances and wraps, and whether the mask marks exactly the touched registers. A write that grows past the staging capacity shows whether the overflow byte is refused without disturbing the earlier bytes. Writes that end by repeated start, by a dropped enable, or with a trailing partial byte show whether commit is tied only to a clean stop and to complete bytes. A multi-byte read closed by a NACK shows whether the returned data follows the live file and the offset advance.

// File: rtl/regport_pkg.sv
package regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_ACK_RD
  } rp_state_t;
endpackage

// File: rtl/twowire_cond.sv
module twowire_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_prev <= scl_sync[1];
      sda_prev <= sda_sync[1];
    end
  end

  assign sda_lvl   = sda_sync[1];
  assign scl_rise  = scl_sync[1] & ~scl_prev;
  assign scl_fall  = ~scl_sync[1] & scl_prev;
  assign start_det = scl_sync[1] & scl_prev & sda_prev & ~sda_sync[1];
  assign stop_det  = scl_sync[1] & scl_prev & ~sda_prev & sda_sync[1];
endmodule

// File: rtl/regport_stage.sv
module regport_stage #(
  parameter int NREG  = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(NREG),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            put,
  input  logic [AW-1:0]   put_addr,
  input  logic [7:0]      put_data,
  output logic [CW-1:0]   count,
  output logic [NREG-1:0] mask,
  output logic [NREG*8-1:0] data
);
  logic [7:0] slot [NREG];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask  <= '0;
      count <= '0;
    end else if (put) begin
      mask[put_addr] <= 1'b1;
      count          <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (put) slot[put_addr] <= put_data;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_flat
    assign data[8*k +: 8] = slot[k];
  end
endmodule

// File: rtl/i2c_commit_regport.sv
module i2c_commit_regport
  import regport_pkg::*;
#(
  parameter int         NREG     = 32,
  parameter int         DEPTH    = 32,
  parameter logic [6:0] DEV_ADDR = 7'h68,
  localparam int AW = $clog2(NREG),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [AW-1:0]     rd_addr,
  input  logic [7:0]        rd_data,
  output logic              reg_wr_stb,
  output logic [NREG-1:0]   reg_wr_mask,
  output logic [NREG*8-1:0] reg_wr_data
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  rp_state_t st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic              rw_q, first_q, mack_q;
  logic [AW-1:0]     ptr;
  logic              stg_put, stg_clr;
  logic [AW-1:0]     stg_addr;
  logic [7:0]        stg_byte;
  logic [CW-1:0]     stg_cnt;
  logic [NREG-1:0]   stg_mask;
  logic [NREG*8-1:0] stg_data;

  twowire_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  regport_stage #(.NREG(NREG), .DEPTH(DEPTH)) u_stage (
    .clk(clk), .rst(rst), .clr(stg_clr), .put(stg_put),
    .put_addr(stg_addr), .put_data(stg_byte),
    .count(stg_cnt), .mask(stg_mask), .data(stg_data)
  );

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      rw_q        <= 1'b0;
      first_q     <= 1'b0;
      mack_q      <= 1'b0;
      ptr         <= '0;
      sda_oe      <= 1'b0;
      stg_put     <= 1'b0;
      stg_clr     <= 1'b1;
      stg_addr    <= '0;
      stg_byte    <= '0;
      reg_wr_stb  <= 1'b0;
      reg_wr_mask <= '0;
      reg_wr_data <= '0;
    end else begin
      stg_put    <= 1'b0;
      stg_clr    <= 1'b0;
      reg_wr_stb <= 1'b0;
      if (!bus_en) begin
        st      <= ST_IDLE;
        sda_oe  <= 1'b0;
        stg_clr <= 1'b1;
      end else if (start_det) begin
        st      <= ST_ADDR;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        first_q <= 1'b1;
        stg_clr <= 1'b1;
      end else if (stop_det) begin
        st      <= ST_IDLE;
        sda_oe  <= 1'b0;
        stg_clr <= 1'b1;
        if (stg_cnt != '0) begin
          reg_wr_stb  <= 1'b1;
          reg_wr_mask <= stg_mask;
          reg_wr_data <= stg_data;
        end
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw_q   <= shreg[0];
                  st     <= ST_ACK_ADDR;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st <= ST_ACK_WR;
                if (first_q) begin
                  ptr     <= shreg[AW-1:0];
                  first_q <= 1'b0;
                  sda_oe  <= 1'b1;
                end else if (stg_cnt < CAP) begin
                  stg_put  <= 1'b1;
                  stg_addr <= ptr;
                  stg_byte <= shreg;
                  ptr      <= ptr + 1'b1;
                  sda_oe   <= 1'b1;
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          ST_ACK_ADDR: if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              st     <= ST_RD;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              st     <= ST_WR;
              sda_oe <= 1'b0;
            end
          end
          ST_ACK_WR: if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              st     <= ST_ACK_RD;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_ACK_RD: begin
            if (scl_rise) mack_q <= ~sda_lvl;
            else if (scl_fall) begin
              if (mack_q) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= '0;
                st     <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regport_checker.sv
module regport_checker #(
  parameter int NREG  = 32,
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_en,
  input logic            sda_oe,
  input logic            stop_det,
  input logic            reg_wr_stb,
  input logic [NREG-1:0] reg_wr_mask,
  input logic [CW-1:0]   stg_cnt
);
  // R3: live registers change only on the cycle after a stop
  p_commit_after_stop_r3: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |-> $past(stop_det));
  // R4: single-cycle strobe with a non-empty mask
  p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |=> !reg_wr_stb);
  p_mask_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |-> (reg_wr_mask != '0));
  // R8: staging never holds more than its capacity
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    stg_cnt <= CW'(DEPTH));
  // R9: no drive of SDA once the mode enable is low
  p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_en) |-> !sda_oe);
  // R10: SDA released after stop
  p_release_stop_r10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
endmodule

bind i2c_commit_regport regport_checker #(.NREG(NREG), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .sda_oe(sda_oe),
  .stop_det(stop_det), .reg_wr_stb(reg_wr_stb),
  .reg_wr_mask(reg_wr_mask), .stg_cnt(stg_cnt)
);

// File: tb/tb_i2c_commit_regport.sv
`timescale 1ns/100ps
module tb_i2c_commit_regport;
  localparam int NREG = 32;
  localparam int DEPTH = 32;
  localparam logic [6:0] DA = 7'h68;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic reg_wr_stb;
  logic [NREG-1:0] reg_wr_mask;
  logic [NREG*8-1:0] reg_wr_data;
  logic [7:0] live [NREG];
  logic [NREG-1:0] last_mask;
  int stb_n = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_commit_regport #(.NREG(NREG), .DEPTH(DEPTH), .DEV_ADDR(DA)) dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .reg_wr_stb(reg_wr_stb), .reg_wr_mask(reg_wr_mask), .reg_wr_data(reg_wr_data)
  );

  // model of the live register file fed by the commit port
  assign rd_data = live[rd_addr];
  always @(posedge clk) begin
    if (reg_wr_stb) begin
      stb_n <= stb_n + 1;
      last_mask <= reg_wr_mask;
      for (int k = 0; k < NREG; k++)
        if (reg_wr_mask[k]) live[k] <= reg_wr_data[8*k +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; tick(Q); scl = 1; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; tick(Q); scl = 1; tick(Q);
    ack = !sda_line;
    scl = 0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    b = '0;
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1; tick(Q);
      b = {b[6:0], sda_line};
      scl = 0;
    end
    tick(Q);
    sda_m = !mack; tick(Q); scl = 1; tick(Q); scl = 0; tick(Q);
    sda_m = 1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 0, "R10 reset sda_oe", sda_oe, 0);
    chk(reg_wr_stb == 0, "R4 reset strobe", reg_wr_stb, 0);
    chk(rd_addr == 0, "R5 reset offset", rd_addr, 0);
  endtask

  task automatic t_address();
    bit a;
    bus_start(); send_byte({7'h22, 1'b0}, a); bus_stop();
    chk(a == 0, "R1 wrong address acked", a, 0);
    bus_start(); send_byte({DA, 1'b0}, a);
    chk(a == 1, "R1 own address ack", a, 1);
    bus_stop();
    chk(sda_oe == 0, "R10 released after stop", sda_oe, 0);
  endtask

  task automatic t_block_write();
    bit a; int s0;
    s0 = stb_n;
    bus_start(); send_byte({DA, 1'b0}, a); send_byte(8'h05, a);
    send_byte(8'hA1, a); send_byte(8'hB2, a); send_byte(8'hC3, a);
    chk(a == 1, "R2 data byte ack", a, 1);
    chk(stb_n == s0, "R3 no write before stop", stb_n, s0);
    bus_stop();
    chk(stb_n == s0 + 1, "R4 one strobe at stop", stb_n, s0 + 1);
    chk(last_mask == 32'h0000_00E0, "R4 mask bits", last_mask, 32'h0000_00E0);
    chk(live[5] == 8'hA1 && live[6] == 8'hB2 && live[7] == 8'hC3, "R2 consecutive offsets",
        {live[5], live[6], live[7]}, 24'hA1B2C3);
    // wrap across the top of the file
    bus_start(); send_byte({DA, 1'b0}, a); send_byte(8'h1F, a);
    send_byte(8'h3C, a); send_byte(8'h4D, a); bus_stop();
    chk(last_mask == 32'h8000_0001, "R2 wrap mask", last_mask, 32'h8000_0001);
    chk(live[31] == 8'h3C && live[0] == 8'h4D, "R2 wrap data", {live[31], live[0]}, 16'h3C4D);
  endtask

  task automatic t_read();
    bit a; int s0; logic [7:0] b0, b1, b2;
    s0 = stb_n;
    bus_start(); send_byte({DA, 1'b0}, a); send_byte(8'h05, a); bus_stop();
    chk(stb_n == s0, "R4 pointer-only write gives no strobe", stb_n, s0);
    bus_start(); send_byte({DA, 1'b1}, a);
    recv_byte(b0, 1); recv_byte(b1, 1); recv_byte(b2, 0);
    chk(b0 == 8'hA1, "R5 read byte 0", b0, 8'hA1);
    chk(b1 == 8'hB2, "R5 read byte 1", b1, 8'hB2);
    chk(b2 == 8'hC3, "R5 read byte 2", b2, 8'hC3);
    chk(rd_addr == 5'd8, "R5 offset advanced", rd_addr, 8);
    chk(sda_oe == 0, "R5 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_restart();
    bit a; int s0;
    s0 = stb_n;
    bus_start(); send_byte({DA, 1'b0}, a); send_byte(8'h10, a);
    send_byte(8'hAA, a); send_byte(8'hBB, a);
    bus_start(); send_byte({DA, 1'b0}, a); bus_stop();
    chk(stb_n == s0, "R6 repeated start discards", stb_n, s0);
    chk(live[16] == 8'h00, "R6 register untouched", live[16], 0);
  endtask

  task automatic t_partial();
    bit a;
    bus_start(); send_byte({DA, 1'b0}, a); send_byte(8'h08, a); send_byte(8'h11, a);
    send_bit(1); send_bit(0); send_bit(1);
    bus_stop();
    chk(last_mask == 32'h0000_0100, "R7 only complete byte", last_mask, 32'h0000_0100);
    chk(live[8] == 8'h11 && live[9] == 8'h00, "R7 partial dropped", {live[8], live[9]}, 16'h1100);
  endtask

  task automatic t_capacity();
    bit a;
    bus_start(); send_byte({DA, 1'b0}, a); send_byte(8'h00, a);
    for (int i = 0; i < DEPTH; i++) send_byte(8'h40 + 8'(i), a);
    chk(a == 1, "R8 last fitting byte acked", a, 1);
    send_byte(8'hEE, a);
    chk(a == 0, "R8 overflow byte nacked", a, 0);
    bus_stop();
    chk(last_mask == '1, "R8 full mask", last_mask, 32'hFFFF_FFFF);
    chk(live[0] == 8'h40, "R8 overflow not committed", live[0], 8'h40);
    chk(live[31] == 8'h5F, "R8 last byte", live[31], 8'h5F);
  endtask

  task automatic t_disabled();
    bit a; int s0;
    s0 = stb_n;
    bus_en = 0; tick(4);
    bus_start(); send_byte({DA, 1'b0}, a);
    chk(a == 0, "R9 no ack when disabled", a, 0);
    send_byte(8'h02, a); send_byte(8'h77, a); bus_stop();
    chk(stb_n == s0, "R9 no strobe when disabled", stb_n, s0);
    bus_en = 1; tick(4);
    bus_start(); send_byte({DA, 1'b0}, a); send_byte(8'h02, a); send_byte(8'h77, a);
    bus_en = 0; tick(4); bus_en = 1; tick(4);
    bus_stop();
    chk(stb_n == s0, "R9 enable drop discards", stb_n, s0);
    chk(live[2] == 8'h42, "R9 register kept", live[2], 8'h42);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) live[k] = 8'h00;
    tick(4); rst = 0; tick(4);
    t_reset();
    t_address();
    t_block_write();
    t_read();
    t_restart();
    t_partial();
    t_capacity();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule